// File: doc/BRIEF.md
# Programmable Output-Compare Timer

This block is a single-channel timer. A prescaler divides the clock into counter ticks, an up-counter runs from zero to a programmable limit and wraps, and a compare unit watches the count. Each time the count equals the compare value on a tick, the channel takes one of three actions on its output pin. It can invert the pin, force it high, or force it low.

The action is picked at runtime. A one-cycle strobe steps the channel to the next action in a fixed ring while the timer keeps counting. The prescaler, limit and compare inputs are not used straight away. They are captured into working copies only at the wrap of the counter, so a new setting never cuts a period short. Each wrap gives a one-cycle update pulse, and each compare hit gives a one-cycle match pulse.

Top module: `oc_timer`

## Requirements
- R1: While `en` stays high, update pulses are spaced exactly (P+1)*(A+1) clock cycles apart, where P and A are the working prescaler and limit values for that period. The counter advances once every P+1 clocks.
- R2: The counter runs 0, 1, ... A and then returns to 0. On the tick where the count equals A, the wrap happens, and `upd_pulse` is high for exactly one cycle, in the clock cycle after that tick.
- R3: In invert mode (mode code 0), a compare hit inverts `oc_out` one cycle after the matching tick.
- R4: In force-high mode (mode code 1), a compare hit drives `oc_out` to 1 one cycle after the matching tick.
- R5: In force-low mode (mode code 2), a compare hit drives `oc_out` to 0 one cycle after the matching tick.
- R6: Synchronous reset sets `oc_out`, `upd_pulse` and `match_pulse` to 0 and selects invert mode. It clears the prescaler, the counter and all working copies to 0, so the first enabled clock after reset is a wrap that loads the inputs.
- R7: Each clock with `mode_step` high moves the mode one step around the ring: invert, force-high, force-low, then back to invert.
- R8: A mode step never changes `oc_out` by itself. `oc_out` changes only in the cycle after a compare hit.
- R9: `match_pulse` is high in the cycle after every tick on which the count equals the working compare value, and at no other time. A compare value above the limit never matches.
- R10: Changes to `psc_in`, `arr_in` and `cmp_in` take effect only at the next wrap. Changes in the middle of a period do not change that period's length or its compare point.
- R11: With `en` low, the prescaler and the counter hold their values, and no tick, update pulse or match pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| psc_in | input | PSC_W | Prescaler setting; tick every psc_in+1 clocks |
| arr_in | input | CNT_W | Counter limit; period is arr_in+1 ticks |
| cmp_in | input | CNT_W | Compare value |
| mode_step | input | 1 | One-cycle strobe that advances the match action |
| oc_out | output | 1 | Registered compare output pin |
| upd_pulse | output | 1 | One-cycle pulse after each wrap |
| match_pulse | output | 1 | One-cycle pulse after each compare hit |

## Verification
The assertions rely on `rst` being synchronous and held for at least one edge, and on the inputs being stable around the clock edge. The timing assertions compare each registered output with the internal tick and hit signals of the previous cycle. They therefore assume that `en`, `mode_step` and the setting inputs are driven only between edges. The bench drives every input on the falling edge. It varies the settings in the middle of a period, lowers the enable for stretches, pulses the mode strobe both alone and back to back, and uses compare values above the limit. A reference model checks the output of every cycle, and a separate check measures the spacing between update pulses.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  typedef enum logic [1:0] {
    OC_INVERT  = 2'd0,
    OC_FORCE_H = 2'd1,
    OC_FORCE_L = 2'd2
  } oc_mode_e;

  function automatic oc_mode_e oc_next_mode(input oc_mode_e m);
    case (m)
      OC_INVERT:  return OC_FORCE_H;
      OC_FORCE_H: return OC_FORCE_L;
      default:    return OC_INVERT;
    endcase
  endfunction
endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc_lim,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = en && (div_q == psc_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= tick ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] arr_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] cnt,
  output logic [PSC_W-1:0] psc_sh,
  output logic [CNT_W-1:0] arr_sh,
  output logic [CNT_W-1:0] cmp_sh,
  output logic             wrap
);
  assign wrap = tick && (cnt == arr_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      psc_sh <= '0;
      arr_sh <= '0;
      cmp_sh <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        psc_sh <= psc_in;
        arr_sh <= arr_in;
        cmp_sh <= cmp_in;
      end
    end
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_sh,
  input  logic             mode_step,
  output logic             match_ev,
  output oc_mode_e         mode,
  output logic             oc_out,
  output logic             match_pulse
);
  assign match_ev = tick && (cnt == cmp_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_out      <= 1'b0;
      match_pulse <= 1'b0;
      mode        <= OC_INVERT;
    end else begin
      match_pulse <= match_ev;
      if (match_ev) begin
        case (mode)
          OC_INVERT:  oc_out <= ~oc_out;
          OC_FORCE_H: oc_out <= 1'b1;
          default:    oc_out <= 1'b0;
        endcase
      end
      if (mode_step) mode <= oc_next_mode(mode);
    end
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] arr_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             mode_step,
  output logic             oc_out,
  output logic             upd_pulse,
  output logic             match_pulse
);
  logic             tick;
  logic             wrap;
  logic             match_ev;
  logic [CNT_W-1:0] cnt;
  logic [PSC_W-1:0] psc_sh;
  logic [CNT_W-1:0] arr_sh;
  logic [CNT_W-1:0] cmp_sh;
  oc_mode_e         mode;

  oc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .en(en), .psc_lim(psc_sh), .tick(tick)
  );

  oc_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .psc_in(psc_in), .arr_in(arr_in), .cmp_in(cmp_in),
    .cnt(cnt), .psc_sh(psc_sh), .arr_sh(arr_sh), .cmp_sh(cmp_sh),
    .wrap(wrap)
  );

  oc_channel #(.CNT_W(CNT_W)) u_ch (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp_sh(cmp_sh),
    .mode_step(mode_step), .match_ev(match_ev), .mode(mode),
    .oc_out(oc_out), .match_pulse(match_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) upd_pulse <= 1'b0;
    else     upd_pulse <= wrap;
  end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             tick,
  input logic             wrap,
  input logic             match_ev,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_sh,
  input oc_mode_e         mode,
  input logic             oc_out,
  input logic             upd_pulse,
  input logic             match_pulse
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!oc_out && !upd_pulse && !match_pulse && mode == OC_INVERT)); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= arr_sh); // R2
  AST_UPD_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (upd_pulse == $past(wrap))); // R2
  AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(tick)); // R9
  AST_OC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(match_ev)) |-> $stable(oc_out)); // R8
  AST_INVERT_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match_ev) && $past(mode) == OC_INVERT) |-> (oc_out != $past(oc_out))); // R3
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match_ev) && $past(mode) == OC_FORCE_H) |-> oc_out); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match_ev) && $past(mode) == OC_FORCE_L) |-> !oc_out); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> ($stable(cnt) && !upd_pulse && !match_pulse)); // R11
endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick), .wrap(wrap),
  .match_ev(match_ev), .cnt(cnt), .arr_sh(arr_sh), .mode(mode),
  .oc_out(oc_out), .upd_pulse(upd_pulse), .match_pulse(match_pulse)
);

// File: tb/oc_timer_bench.sv
`timescale 1ns/1ps
module oc_timer_bench;
  localparam int PW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [PW-1:0] psc_in = '0;
  logic [CW-1:0] arr_in = '0;
  logic [CW-1:0] cmp_in = '0;
  logic          mode_step = 1'b0;
  logic          oc_out, upd_pulse, match_pulse;

  always #4 clk = ~clk;

  oc_timer #(.PSC_W(PW), .CNT_W(CW)) u_oc_timer (
    .clk(clk), .rst(rst), .en(en), .psc_in(psc_in), .arr_in(arr_in),
    .cmp_in(cmp_in), .mode_step(mode_step), .oc_out(oc_out),
    .upd_pulse(upd_pulse), .match_pulse(match_pulse)
  );

  typedef struct packed {
    logic oc;
    logic upd;
    logic mt;
    logic rst_item;
    logic idle;
    logic stepped;
    logic [3:0] otag;
    int   gap;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // reference model state
  int m_pc = 0, m_cnt = 0, m_psc = 0, m_arr = 0, m_cmp = 0, m_mode = 0;
  logic m_oc = 1'b0, m_ok = 1'b0, m_stepped = 1'b0;

  function automatic string otag_name(input logic [3:0] t, input logic st);
    string s;
    case (t)
      4'd3: s = "R3";
      4'd4: s = "R4";
      4'd5: s = "R5";
      4'd6: s = "R6";
      default: s = "R8";
    endcase
    if (st && t != 4'd6) s = {s, " R7"};
    return s;
  endfunction

  // model: predicts the outputs seen after each rising edge
  always @(posedge clk) begin
    exp_t e;
    logic tk, up, mt;
    e = '0;
    e.gap = -1;
    if (rst) begin
      m_pc = 0; m_cnt = 0; m_psc = 0; m_arr = 0; m_cmp = 0; m_mode = 0;
      m_oc = 1'b0; m_ok = 1'b0; m_stepped = 1'b0;
      e.rst_item = 1'b1;
      e.otag = 4'd6;
    end else begin
      tk = en && (m_pc == m_psc);
      up = tk && (m_cnt == m_arr);
      mt = tk && (m_cnt == m_cmp);
      if (up && m_ok) e.gap = (m_psc + 1) * (m_arr + 1);
      e.otag = 4'd8;
      if (mt) begin
        e.otag = 4'(3 + m_mode);
        case (m_mode)
          0: m_oc = ~m_oc;
          1: m_oc = 1'b1;
          default: m_oc = 1'b0;
        endcase
      end
      if (en) m_pc = tk ? 0 : m_pc + 1;
      if (tk) m_cnt = up ? 0 : m_cnt + 1;
      if (up) begin
        m_psc = int'(psc_in); m_arr = int'(arr_in); m_cmp = int'(cmp_in);
      end
      m_ok = en ? (up ? 1'b1 : m_ok) : 1'b0;
      e.stepped = m_stepped;
      if (mode_step) begin
        m_mode = (m_mode == 2) ? 0 : m_mode + 1;
        m_stepped = 1'b1;
      end
      e.upd = up;
      e.mt = mt;
      e.idle = !en;
    end
    e.oc = m_oc;
    exp_q.push_back(e);
  end

  // monitor: compares after each edge, away from it
  int mon_gap = 0;
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (oc_out !== e.oc) begin
        errors++;
        $display("FAIL %s oc_out act=%0b exp=%0b t=%0t", otag_name(e.otag, e.stepped), oc_out, e.oc, $time);
      end
      checks++;
      if (upd_pulse !== e.upd) begin
        errors++;
        $display("FAIL %s upd_pulse act=%0b exp=%0b t=%0t",
                 e.rst_item ? "R6" : (e.idle ? "R11" : "R2"), upd_pulse, e.upd, $time);
      end
      checks++;
      if (match_pulse !== e.mt) begin
        errors++;
        $display("FAIL %s match_pulse act=%0b exp=%0b t=%0t",
                 e.rst_item ? "R6" : (e.idle ? "R11" : "R9"), match_pulse, e.mt, $time);
      end
      mon_gap++;
      if (upd_pulse === 1'b1) begin
        if (e.gap >= 0) begin
          checks++;
          if (mon_gap != e.gap) begin
            errors++;
            $display("FAIL R1 R10 update spacing act=%0d exp=%0d t=%0t", mon_gap, e.gap, $time);
          end
        end
        mon_gap = 0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int a, input int c);
    @(negedge clk);
    psc_in = PW'(p); arr_in = CW'(a); cmp_in = CW'(c);
  endtask

  task automatic step_mode;
    @(negedge clk); mode_step = 1'b1;
    @(negedge clk); mode_step = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    set_cfg(2, 4, 2);
    rst = 1'b0;
    wait_cyc(4);               // R11: idle with en low after reset
    en = 1'b1;
    wait_cyc(80);              // R3 invert mode, R1 spacing
    step_mode();               // R7 -> force high, R8 no immediate effect
    wait_cyc(40);              // R4
    step_mode();               // -> force low
    wait_cyc(40);              // R5
    step_mode();               // -> invert again
    wait_cyc(40);
    set_cfg(0, 7, 5);          // R10 change mid period
    wait_cyc(3);
    set_cfg(1, 3, 3);
    wait_cyc(60);
    @(negedge clk); mode_step = 1'b1;
    @(negedge clk);            // back-to-back steps
    @(negedge clk); mode_step = 1'b0;
    wait_cyc(40);
    @(negedge clk); en = 1'b0; // R11 freeze
    wait_cyc(10);
    @(negedge clk); en = 1'b1;
    wait_cyc(40);
    set_cfg(1, 4, 9);          // R9 compare above limit never hits
    wait_cyc(40);
    set_cfg(0, 0, 0);          // every tick wraps and matches
    wait_cyc(20);
    set_cfg(3, 2, 0);
    wait_cyc(30);
    @(negedge clk); rst = 1'b1; // R6 reset in mid run
    @(negedge clk); rst = 1'b0;
    wait_cyc(40);
    @(negedge clk);
    finish_run();
  end

  initial begin
    wait_cyc(200000);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    finish_run();
  end
endmodule